// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block runs one full-duplex serial exchange with a single peripheral each time it receives a start pulse. It drives the serial clock, the outbound data line and an active-low select, and it captures the inbound data line. Its configuration covers the idle clock level, the clock phase, the word length, the bit order and a power-of-two clock divider. All of these are captured when a start pulse is accepted, so the controlling logic may change them while an exchange is running.

The select stays low for the whole frame. With the default divider setting, each half of a serial clock period lasts one system clock cycle. Once the frame has closed, the received word appears right-aligned on the output, and a one-cycle completion pulse marks that it is ready.

Top module: `spi_xfer_master`

## Requirements
- R1: Out of reset, and whenever no exchange is in progress, `sel_n` is 1, `busy` is 0 and `sclk` rests at the `cpol` level. Reset also clears `done` and `rx_word`, and `sclk` resets to 0.
- R2: With `cpha`=0, `mosi` carries the first bit of the frame from the cycle in which `sel_n` falls, before any `sclk` edge. Bits are captured on the leading (odd-numbered, counted from 1) `sclk` edges and changed on the trailing edges.
- R3: With `cpha`=1, `mosi` changes on the leading `sclk` edges and is captured on the trailing edges.
- R4: The capture edge is a rising edge when `cpol` equals `cpha` (modes 0 and 3), and a falling edge otherwise (modes 1 and 2).
- R5: With `lsb_first`=0, bit N-1 of `tx_word` is sent first, and the first bit received lands in `rx_word[N-1]`. With `lsb_first`=1, bit 0 goes first in both directions. `rx_word` bits at index N and above read 0.
- R6: The frame length N is `frame_len` clamped to the range 4..32: values below 4 act as 4 and values above 32 act as 32. A frame contains exactly 2N `sclk` edges.
- R7: A `div_sel` value of d gives a half period of 2^d system clocks on `sclk`. The division ratio is therefore 2^(d+1), which covers 2 to 256.
- R8: `sel_n` falls on the clock edge that accepts `start`. The first `sclk` edge follows one half period later, and `sel_n` rises one half period after the last edge. `done` is therefore seen 2^d·(2N+1) cycles after the accepting edge.
- R9: All settings and `tx_word` are captured when `start` is accepted. Changing them during a frame, or pulsing `start` while `busy` is 1, has no effect on the current frame, and the pulse does not begin a new one.
- R10: `done` is high for exactly one cycle, in the cycle where `sel_n` returns high, and `rx_word` holds the received word at that point. `busy` stays 1 from the accepting edge until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one exchange (accepted only when idle) |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| lsb_first | input | 1 | 0: most significant bit first; 1: least significant bit first |
| frame_len | input | 6 | Word length in bits, clamped to 4..32 |
| div_sel | input | 3 | Half period of `sclk` is 2^div_sel system clocks |
| tx_word | input | 32 | Word to send, right-aligned |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| sel_n | output | 1 | Active-low peripheral select |
| rx_word | output | 32 | Received word, right-aligned, valid with `done` |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that `miso` changes only away from the capture edges, and that `rst` is held for at least one clock edge before the first start. The bench's peripheral model enforces both. It changes `miso` only in response to shift edges or to the falling select, and it releases reset after several cycles. The properties place no limits on the configuration inputs. To exercise R9, the stimulus deliberately scrambles every setting right after a start has been accepted, and it also pulses `start` while a frame is running.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } spim_state_e;

endpackage

// File: rtl/spim_half_timer.sv
// Produces one tick every 2^div_sel system clocks; restart realigns the count.
module spim_half_timer #(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   span;

  always_comb begin
    span  = (CNT_W+1)'(1) << div_sel;
    limit = CNT_W'(span - 1'b1);
    tick  = (cnt_q == limit) && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  half_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);

endmodule

// File: rtl/spim_bit_pick.sv
// Maps the n-th bit of a frame to its word position for either bit order.
module spim_bit_pick #(
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic             lsb,
  input  logic [LEN_W-1:0] nbits,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] pos
);

  logic [LEN_W-1:0] rev;

  always_comb begin
    rev = nbits - LEN_W'(1) - LEN_W'(idx);
    pos = lsb ? idx : IDX_W'(rev);
  end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 3,
  localparam int LEN_W  = $clog2(MAX_BITS + 1),
  localparam int IDX_W  = $clog2(MAX_BITS),
  localparam int EDGE_W = $clog2(2 * MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                lsb_first,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic [DIV_W-1:0]    div_sel,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                sel_n,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                busy,
  output logic                done
);

  import spim_pkg::*;

  spim_state_e         state_q;
  logic                cpol_q, cpha_q, lsb_q;
  logic [LEN_W-1:0]    nbits_q, nbits_in;
  logic [DIV_W-1:0]    div_q;
  logic [MAX_BITS-1:0] tx_q, rx_q, rx_word_q;
  logic [IDX_W-1:0]    drv_q, smp_q, drv_idx, drv_pos, smp_pos;
  logic [EDGE_W-1:0]   edge_q, edge_last;
  logic                sclk_q, sel_n_q, mosi_q, busy_q, done_q;
  logic                tick, accept, sample_edge, shift_edge;
  logic                drv_lsb;
  logic [LEN_W-1:0]    drv_len;
  logic [MAX_BITS-1:0] drv_word;

  assign accept = start && (state_q == ST_IDLE);

  // Length clamp applied at capture time
  always_comb begin
    if (frame_len < LEN_W'(MIN_BITS))      nbits_in = LEN_W'(MIN_BITS);
    else if (frame_len > LEN_W'(MAX_BITS)) nbits_in = LEN_W'(MAX_BITS);
    else                                   nbits_in = frame_len;
  end

  // Next outbound bit: first bit at acceptance, following bit otherwise
  always_comb begin
    drv_lsb  = accept ? lsb_first : lsb_q;
    drv_len  = accept ? nbits_in  : nbits_q;
    drv_idx  = accept ? '0        : drv_q + 1'b1;
    drv_word = accept ? tx_word   : tx_q;
  end

  spim_bit_pick #(.MAX_BITS(MAX_BITS)) u_drv_pick (
    .lsb(drv_lsb), .nbits(drv_len), .idx(drv_idx), .pos(drv_pos)
  );

  spim_bit_pick #(.MAX_BITS(MAX_BITS)) u_smp_pick (
    .lsb(lsb_q), .nbits(nbits_q), .idx(smp_q), .pos(smp_pos)
  );

  spim_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .div_sel(div_q), .tick(tick)
  );

  // Edge classification: even edge_q values are leading edges
  always_comb begin
    edge_last   = EDGE_W'({nbits_q, 1'b0} - 1'b1);
    sample_edge = (~edge_q[0]) ^ cpha_q;
    shift_edge  = !sample_edge && (edge_q != '0) && (edge_q != edge_last);
  end

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      state_q   <= ST_IDLE;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      lsb_q     <= 1'b0;
      nbits_q   <= LEN_W'(MIN_BITS);
      div_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_word_q <= '0;
      drv_q     <= '0;
      smp_q     <= '0;
      edge_q    <= '0;
      sclk_q    <= 1'b0;
      sel_n_q   <= 1'b1;
      mosi_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            cpol_q  <= cpol;
            cpha_q  <= cpha;
            lsb_q   <= lsb_first;
            nbits_q <= nbits_in;
            div_q   <= div_sel;
            tx_q    <= tx_word;
            rx_q    <= '0;
            drv_q   <= '0;
            smp_q   <= '0;
            edge_q  <= '0;
            mosi_q  <= drv_word[drv_pos];
            sel_n_q <= 1'b0;
            busy_q  <= 1'b1;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (sample_edge) begin
              rx_q[smp_pos] <= miso;
              smp_q         <= smp_q + 1'b1;
            end
            if (shift_edge) begin
              drv_q  <= drv_q + 1'b1;
              mosi_q <= drv_word[drv_pos];
            end
            if (edge_q == edge_last) state_q <= ST_TAIL;
            else                     edge_q  <= edge_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            sel_n_q   <= 1'b1;
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            rx_word_q <= rx_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign sel_n   = sel_n_q;
  assign rx_word = rx_word_q;
  assign busy    = busy_q;
  assign done    = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10
  done_sel_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $rose(sel_n_q));

  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> sel_n_q);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(tx_q) && $stable(nbits_q) && $stable(cpha_q)));

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((nbits_q >= LEN_W'(MIN_BITS)) && (nbits_q <= LEN_W'(MAX_BITS))));

  // R2
  first_edge_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_XFER) && (edge_q == '0)) |-> (sclk_q == cpol_q));

  // R8
  tail_level_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TAIL) |-> ((sclk_q == cpol_q) && !sel_n_q));

endmodule

// File: tb/spi_xfer_master_test.sv
module spi_xfer_master_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [5:0]  frame_len = 6'd8;
  logic [2:0]  div_sel = 3'd0;
  logic [31:0] tx_word = '0;
  logic        miso = 1'b0;
  logic        sclk, mosi, sel_n, busy, done;
  logic [31:0] rx_word;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_xfer_master uut (
    .clk(clk), .rst(rst), .start(start), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .frame_len(frame_len), .div_sel(div_sel),
    .tx_word(tx_word), .miso(miso), .sclk(sclk), .mosi(mosi),
    .sel_n(sel_n), .rx_word(rx_word), .busy(busy), .done(done)
  );

  // Peripheral model
  int          s_n = 8;
  bit          s_lsb = 1'b0, s_cpha = 1'b0, s_cpol = 1'b0;
  logic [31:0] s_data = '0;
  logic [31:0] s_got = '0;
  int          s_edges = 0;
  int          s_bits = 0;
  int          s_dir_err = 0;

  function automatic int bpos(input int i);
    return s_lsb ? i : (s_n - 1 - i);
  endfunction

  always @(negedge sel_n) begin
    s_edges = 0;
    s_bits  = 0;
    s_got   = '0;
    if (!s_cpha) miso = s_data[bpos(0)];
  end

  always @(sclk) begin
    if (sel_n === 1'b0 && rst === 1'b0) begin
      bit lead;
      lead = (s_edges % 2 == 0);
      if (lead != s_cpha) begin
        if (sclk !== (s_cpol == s_cpha)) s_dir_err++;
        if (s_bits < s_n) s_got[bpos(s_bits)] = mosi;
        s_bits++;
      end else if (s_bits < s_n) begin
        miso = s_data[bpos(s_bits)];
      end
      s_edges++;
    end
  end

  task automatic check(input string req, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input bit cp, input bit ph, input bit lsb,
                          input int len_in, input int dv,
                          input logic [31:0] tx, input logic [31:0] sd,
                          input bit poke);
    int n, half, cyc, limit;
    bit seen_bad;
    logic [31:0] mask;
    n = (len_in < 4) ? 4 : ((len_in > 32) ? 32 : len_in);
    half = 1 << dv;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    limit = half * (2 * n + 1) + 16;

    @(negedge clk);
    cpol = cp; cpha = ph; lsb_first = lsb;
    frame_len = 6'(len_in); div_sel = 3'(dv); tx_word = tx;
    s_n = n; s_lsb = lsb; s_cpha = ph; s_cpol = cp; s_data = sd; s_dir_err = 0;
    @(negedge clk);
    @(negedge clk);
    // R1 idle levels follow the configured polarity
    check("R1 idle", sel_n == 1'b1 && sclk == cp && busy == 1'b0,
          {61'd0, sel_n, sclk, busy}, {61'd0, 1'b1, cp, 1'b0});

    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R9 scramble every setting once the frame has been accepted
    cpol = ~cp; cpha = ~ph; lsb_first = ~lsb;
    frame_len = 6'd9; div_sel = ~(3'(dv)); tx_word = ~tx;
    // R8 select falls on the accepting edge
    check("R8 select low", sel_n == 1'b0 && busy == 1'b1 && sclk == cp,
          {61'd0, sel_n, busy, sclk}, {61'd0, 1'b0, 1'b1, cp});
    if (!ph) begin
      // R2 first bit present before any clock edge
      check("R2 first bit", mosi == tx[lsb ? 0 : n - 1],
            {63'd0, mosi}, {63'd0, tx[lsb ? 0 : n - 1]});
    end

    cyc = 0;
    seen_bad = 1'b0;
    while (cyc < limit) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (poke && cyc == 1) start = 1'b1;
      else start = 1'b0;
      if (done) break;
      if (!(busy == 1'b1 && sel_n == 1'b0)) seen_bad = 1'b1;
    end
    start = 1'b0;

    // R10 busy and select held through the frame
    check("R10 busy held", !seen_bad, {63'd0, seen_bad}, 64'd0);
    // R7 R8 frame duration from divider and length
    check("R7 duration", cyc == half * (2 * n + 1), 64'(cyc), 64'(half * (2 * n + 1)));
    // R10 done with select released
    check("R10 done", done == 1'b1 && sel_n == 1'b1 && busy == 1'b0,
          {61'd0, done, sel_n, busy}, {61'd0, 3'b110});
    // R1 clock back at idle level
    check("R1 end level", sclk == cp, {63'd0, sclk}, {63'd0, cp});
    // R5 received word and order
    check("R5 rx word", rx_word == (sd & mask), {32'd0, rx_word}, {32'd0, sd & mask});
    // R2 / R3 data seen by the peripheral on the capture edges
    check(ph ? "R3 tx data" : "R2 tx data", s_got == (tx & mask),
          {32'd0, s_got}, {32'd0, tx & mask});
    // R6 edge count
    check("R6 edges", s_edges == 2 * n, 64'(s_edges), 64'(2 * n));
    // R4 capture edge direction
    check("R4 edge dir", s_dir_err == 0, 64'(s_dir_err), 64'd0);

    @(negedge clk);
    // R10 single-cycle pulse
    check("R10 pulse", done == 1'b0, {63'd0, done}, 64'd0);
    if (poke) begin
      @(negedge clk);
      // R9 start during busy did not begin a new frame
      check("R9 no restart", sel_n == 1'b1 && busy == 1'b0,
            {62'd0, sel_n, busy}, {62'd0, 2'b10});
    end
    cpol = cp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k;
    logic [31:0] tx, sd;
    k = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", sel_n == 1'b1 && busy == 1'b0 && done == 1'b0 &&
          rx_word == 32'd0 && sclk == 1'b0,
          {28'd0, rx_word, sel_n, busy, done, sclk}, {28'd0, 32'd0, 4'b1000});

    // Full sweep: all modes, both orders, every length, fastest divider
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int len = 4; len <= 32; len++) begin
          k++;
          tx = (32'h9E37_79B9 * 32'(k)) ^ 32'h5A5A_1234;
          sd = {tx[15:0], tx[31:16]} ^ 32'hC3A5_0F96;
          run_xfer(m[1], m[0], o[0], len, 0, tx, sd, 1'b0);
        end
      end
    end

    // R7 every divider setting
    for (int d = 0; d < 8; d++) begin
      k++;
      tx = (32'h9E37_79B9 * 32'(k)) ^ 32'h0F0F_A55A;
      sd = ~tx;
      run_xfer(d[0], d[1], d[2], 8, d, tx, sd, 1'b0);
    end

    // R6 length clamping
    run_xfer(1'b0, 1'b0, 1'b0, 0,  1, 32'h0000_000B, 32'h0000_0006, 1'b0);
    run_xfer(1'b1, 1'b1, 1'b1, 3,  1, 32'h0000_0005, 32'h0000_000E, 1'b0);
    run_xfer(1'b0, 1'b1, 1'b0, 40, 0, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0);
    run_xfer(1'b1, 1'b0, 1'b1, 63, 0, 32'h8000_0001, 32'h7FFF_FFFE, 1'b0);

    // R9 start pulses while busy
    run_xfer(1'b0, 1'b0, 1'b0, 12, 2, 32'h0000_0ABC, 32'h0000_0555, 1'b1);
    run_xfer(1'b1, 1'b1, 1'b1, 20, 1, 32'h000F_00F0, 32'h000A_5A5A, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule